// File: doc/BRIEF.md
# Idle Ordered-Set Rate Match FIFO

This block is the clock-compensation buffer of a gigabit Ethernet style receive path. Decoded symbols arrive on the recovered clock. Each symbol is one byte plus a control flag. They leave on the local reference clock. The two clocks may differ by up to ±100 ppm, which is 200 ppm end to end. The block takes up that drift without ever splitting or reordering frame data.

The buffer corrects drift only with the two-symbol idle set K28.5 followed by D16.2. When the buffer runs too full, it drops such sets on the write side. When it runs too empty, it adds such sets on the read side. The unit of correction is always a whole set, so a shortfall of one symbol still moves two. No correction happens until the word aligner reports lock on the sync input. A pulse output in each clock domain marks every set that was removed or added.

Top module: `idle_rate_matcher`

## Requirements
- R1: Every symbol that is not part of a K28.5 + D16.2 set leaves the block unchanged and in arrival order. The write-side fill level never exceeds DEPTH.
- R2: While `sync_ok` is low, no set is removed and no set is added. Both flag outputs stay low.
- R3: The symbol encodings are fixed. K28.5 has the control flag at 1 and byte 0xBC. D16.2 has the flag at 0 and byte 0x50. D5.6 has the flag at 0 and byte 0xC5. The other idle form, K28.5 followed by D5.6, is never removed or added.
- R4: A D16.2 may arrive directly after a K28.5 while the write-side fill is above DEPTH/2+MARGIN. In that case both symbols are discarded together. While the fill stays at or below that mark, nothing is discarded.
- R5: The read-side fill may be below DEPTH/2-MARGIN while the last two symbols output form a K28.5 + D16.2 set. In that case the next two output cycles carry K28.5 and then D16.2, and no stored symbol is consumed. No set is added at any other time.
- R6: `del_flag` is high for exactly two `wr_clk` cycles per discarded set. Every high run therefore has an even length.
- R7: `ins_flag` is high exactly in the output cycles that carry added symbols. Each run starts on a K28.5 and has an even length.
- R8: While reset is held, `out_valid`, `out_k`, `out_data`, `del_flag` and `ins_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock; one symbol is taken on every rising edge |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| sync_ok | input | 1 | Lock indication from the word aligner, write domain |
| in_k | input | 1 | Control flag of the incoming symbol |
| in_data | input | 8 | Byte of the incoming symbol |
| rd_clk | input | 1 | Local reference clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| out_valid | output | 1 | Output symbol is present this cycle |
| out_k | output | 1 | Control flag of the output symbol |
| out_data | output | 8 | Byte of the output symbol |
| del_flag | output | 1 | Set-removed indication, write domain |
| ins_flag | output | 1 | Set-added indication, read domain |

## Verification
The bench builds the block with DEPTH=32 and MARGIN=4, which puts the watermarks at 12 and 20 symbols. It runs the write clock about 8% faster, and later about 8% slower, than the read clock. That exaggeration makes both watermarks cross within a few hundred cycles, well inside the headroom of the buffer. The run opens with the buffer nearly empty, so the first lock also exercises the burst of added sets that primes it. Each offset phase carries a long run of one idle form, to show that the K28.5 + D5.6 form survives and that the K28.5 + D16.2 form is added back to back.

// File: rtl/irm_pkg.sv
`timescale 1ns/1ps
package irm_pkg;

    typedef struct packed {
        logic       is_ctrl;
        logic [7:0] value;
    } sym_t;

    localparam logic [7:0] COMMA_BYTE   = 8'hBC;
    localparam logic [7:0] I2_TAIL_BYTE = 8'h50;

    localparam sym_t SYM_COMMA   = {1'b1, COMMA_BYTE};
    localparam sym_t SYM_I2_TAIL = {1'b0, I2_TAIL_BYTE};

    typedef enum logic {
        RD_PASS,
        RD_INS_TAIL
    } rd_state_e;

    function automatic logic is_comma(sym_t s);
        return s.is_ctrl && (s.value == COMMA_BYTE);
    endfunction

    function automatic logic is_i2_tail(sym_t s);
        return !s.is_ctrl && (s.value == I2_TAIL_BYTE);
    endfunction

    function automatic logic [31:0] gray_to_bin(logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/irm_sync2.sv
`timescale 1ns/1ps
module irm_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irm_store.sv
`timescale 1ns/1ps
module irm_store
    import irm_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sym_t          wdata,
    input  logic [AW-1:0] raddr,
    output sym_t          rdata
);
    sym_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/irm_wr_ctrl.sv
`timescale 1ns/1ps
module irm_wr_ctrl
    import irm_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int HI_MARK = 20,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_ok,
    input  sym_t          in_sym,
    input  logic [PW-1:0] rptr_gray,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output sym_t          wr_sym,
    output logic [PW-1:0] wptr_gray,
    output logic [PW-1:0] fill,
    output logic          del_flag
);
    sym_t          stage;
    logic          stage_vld;
    logic [PW-1:0] wptr, wptr_next, rptr_bin;
    logic          full, above, pair_hit, drop_set;
    logic [1:0]    flag_cnt;

    assign rptr_bin  = PW'(gray_to_bin(32'(rptr_gray)));
    assign fill      = wptr - rptr_bin;
    assign full      = (fill == PW'(DEPTH));
    assign above     = (fill > PW'(HI_MARK));

    // A held comma plus an arriving D16.2 is one complete removable set
    assign pair_hit  = stage_vld && is_comma(stage) && is_i2_tail(in_sym);
    assign drop_set  = sync_ok && above && pair_hit;

    assign wr_en     = stage_vld && !drop_set && !full;
    assign wr_addr   = wptr[AW-1:0];
    assign wr_sym    = stage;
    assign wptr_next = wptr + PW'(wr_en);
    assign del_flag  = (flag_cnt != 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= '0;
            stage_vld <= 1'b0;
            wptr      <= '0;
            wptr_gray <= '0;
            flag_cnt  <= 2'd0;
        end else begin
            wptr      <= wptr_next;
            wptr_gray <= wptr_next ^ (wptr_next >> 1);
            if (drop_set) begin
                stage_vld <= 1'b0;
            end else begin
                stage     <= in_sym;
                stage_vld <= 1'b1;
            end
            if (drop_set) begin
                flag_cnt <= 2'd2;
            end else if (flag_cnt != 2'd0) begin
                flag_cnt <= flag_cnt - 2'd1;
            end
        end
    end
endmodule

// File: rtl/irm_rd_ctrl.sv
`timescale 1ns/1ps
module irm_rd_ctrl
    import irm_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int LO_MARK = 12,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_ok,
    input  logic [PW-1:0] wptr_gray,
    input  sym_t          rd_sym,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rptr_gray,
    output sym_t          out_sym,
    output logic          out_valid,
    output logic          ins_flag
);
    rd_state_e     state;
    logic [PW-1:0] rptr, rptr_next, wptr_bin, fill;
    logic          prev_comma, set_done, start_ins, empty, below, pop;

    assign wptr_bin  = PW'(gray_to_bin(32'(wptr_gray)));
    assign fill      = wptr_bin - rptr;
    assign empty     = (fill == '0);
    assign below     = (fill < PW'(LO_MARK));

    // The symbol on the output closes a K28.5 + D16.2 set
    assign set_done  = out_valid && is_i2_tail(out_sym) && prev_comma;
    assign start_ins = (state == RD_PASS) && sync_ok && below && set_done;
    assign pop       = (state == RD_PASS) && !start_ins && !empty;
    assign rptr_next = rptr + PW'(pop);
    assign rd_addr   = rptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr       <= '0;
            rptr_gray  <= '0;
            state      <= RD_PASS;
            out_sym    <= '0;
            out_valid  <= 1'b0;
            ins_flag   <= 1'b0;
            prev_comma <= 1'b0;
        end else begin
            rptr       <= rptr_next;
            rptr_gray  <= rptr_next ^ (rptr_next >> 1);
            prev_comma <= out_valid && is_comma(out_sym);
            if (state == RD_INS_TAIL) begin
                out_sym   <= SYM_I2_TAIL;
                out_valid <= 1'b1;
                ins_flag  <= 1'b1;
                state     <= RD_PASS;
            end else if (start_ins) begin
                out_sym   <= SYM_COMMA;
                out_valid <= 1'b1;
                ins_flag  <= 1'b1;
                state     <= RD_INS_TAIL;
            end else if (pop) begin
                out_sym   <= rd_sym;
                out_valid <= 1'b1;
                ins_flag  <= 1'b0;
            end else begin
                out_valid <= 1'b0;
                ins_flag  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/idle_rate_matcher.sv
`timescale 1ns/1ps
module idle_rate_matcher #(
    parameter int DEPTH  = 32,
    parameter int MARGIN = 4
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic       sync_ok,
    input  logic       in_k,
    input  logic [7:0] in_data,
    input  logic       rd_clk,
    input  logic       rd_rst,
    output logic       out_valid,
    output logic       out_k,
    output logic [7:0] out_data,
    output logic       del_flag,
    output logic       ins_flag
);
    import irm_pkg::*;

    localparam int AW      = $clog2(DEPTH);
    localparam int PW      = AW + 1;
    localparam int HI_MARK = DEPTH / 2 + MARGIN;
    localparam int LO_MARK = DEPTH / 2 - MARGIN;

    sym_t          in_sym, wr_sym, rd_sym, out_sym;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] wptr_gray, rptr_gray, wptr_gray_rd, rptr_gray_wr;
    logic [PW-1:0] wr_fill;
    logic          rd_sync_ok;

    assign in_sym   = {in_k, in_data};
    assign out_k    = out_sym.is_ctrl;
    assign out_data = out_sym.value;

    irm_wr_ctrl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK)) u_wr (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .sync_ok   (sync_ok),
        .in_sym    (in_sym),
        .rptr_gray (rptr_gray_wr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_sym    (wr_sym),
        .wptr_gray (wptr_gray),
        .fill      (wr_fill),
        .del_flag  (del_flag)
    );

    irm_store #(.DEPTH(DEPTH)) u_store (
        .wclk  (wr_clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_sym),
        .raddr (rd_addr),
        .rdata (rd_sym)
    );

    irm_sync2 #(.W(PW)) u_rptr_to_wr (
        .clk (wr_clk), .rst (wr_rst), .d (rptr_gray), .q (rptr_gray_wr)
    );

    irm_sync2 #(.W(PW)) u_wptr_to_rd (
        .clk (rd_clk), .rst (rd_rst), .d (wptr_gray), .q (wptr_gray_rd)
    );

    irm_sync2 #(.W(1)) u_lock_to_rd (
        .clk (rd_clk), .rst (rd_rst), .d (sync_ok), .q (rd_sync_ok)
    );

    irm_rd_ctrl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK)) u_rd (
        .clk       (rd_clk),
        .rst       (rd_rst),
        .sync_ok   (rd_sync_ok),
        .wptr_gray (wptr_gray_rd),
        .rd_sym    (rd_sym),
        .rd_addr   (rd_addr),
        .rptr_gray (rptr_gray),
        .out_sym   (out_sym),
        .out_valid (out_valid),
        .ins_flag  (ins_flag)
    );
endmodule

// File: rtl/irm_checker.sv
`timescale 1ns/1ps
module irm_checker #(
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          sync_ok,
    input logic          rd_sync_ok,
    input logic [PW-1:0] wr_fill,
    input logic          del_flag,
    input logic          ins_flag,
    input logic          out_valid,
    input logic          out_k,
    input logic [7:0]    out_data
);
    // R1
    fill_bound_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_fill <= PW'(DEPTH));

    // R6
    del_pair_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(del_flag) |=> del_flag);

    // R2
    del_locked_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(del_flag) |-> $past(sync_ok));

    // R7
    ins_pair_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(ins_flag) |=> ins_flag);

    // R7
    ins_head_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(ins_flag) |-> (out_k && out_data == 8'hBC));

    // R7
    ins_valid_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        ins_flag |-> out_valid);

    // R2
    ins_locked_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(ins_flag) |-> $past(rd_sync_ok));

    // R5
    ins_after_set_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(ins_flag) |-> $past(out_valid && !out_k && out_data == 8'h50));
endmodule

bind idle_rate_matcher irm_checker #(.DEPTH(DEPTH)) u_irm_chk (
    .wr_clk     (wr_clk),
    .wr_rst     (wr_rst),
    .rd_clk     (rd_clk),
    .rd_rst     (rd_rst),
    .sync_ok    (sync_ok),
    .rd_sync_ok (rd_sync_ok),
    .wr_fill    (wr_fill),
    .del_flag   (del_flag),
    .ins_flag   (ins_flag),
    .out_valid  (out_valid),
    .out_k      (out_k),
    .out_data   (out_data)
);

// File: tb/idle_rate_matcher_bench.sv
`timescale 1ns/1ps
module idle_rate_matcher_bench;
    localparam realtime CLK_PERIOD = 10.0;
    localparam int      DEPTH      = 32;
    localparam int      MARGIN     = 4;
    localparam logic [8:0] K_COMMA = 9'h1BC;
    localparam logic [8:0] D_I2    = 9'h050;
    localparam logic [8:0] D_I1    = 9'h0C5;

    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_rst = 1'b1, rd_rst = 1'b1;
    logic       sync_ok = 1'b0, in_k = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_k, del_flag, ins_flag;
    logic [7:0] out_data;

    realtime wr_half = CLK_PERIOD / 2;
    int  n_checks = 0, n_fail = 0;
    bit  wr_go = 0, wr_mon = 0, rd_mon = 0, want_sync = 0, idle_only = 0, done = 0;
    bit  in_pend = 0, out_pend = 0;
    logic [8:0] tx_q[$];
    logic [8:0] exp_q[$];
    int  del_run = 0, del_sets = 0, ins_pos = 0, ins_sets = 0;
    bit  prev_ins = 0;
    logic [8:0] last1 = '0, last2 = '0;
    int unsigned seed_val;

    always #(CLK_PERIOD / 2) rd_clk = ~rd_clk;
    always begin
        #(wr_half);
        wr_clk = ~wr_clk;
    end

    idle_rate_matcher #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_idle_rate_matcher (
        .wr_clk (wr_clk), .wr_rst (wr_rst), .sync_ok (sync_ok),
        .in_k (in_k), .in_data (in_data),
        .rd_clk (rd_clk), .rd_rst (rd_rst),
        .out_valid (out_valid), .out_k (out_k), .out_data (out_data),
        .del_flag (del_flag), .ins_flag (ins_flag)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Stream generator: data packets separated by idle sets
    task automatic add_chunk();
        int n;
        if (!idle_only) begin
            n = 4 + int'($urandom % 17);
            repeat (n) tx_q.push_back({1'b0, 8'($urandom)});
        end
        n = 3 + int'($urandom % 6);
        repeat (n) begin
            if (idle_only || ($urandom % 4) != 0) begin
                tx_q.push_back(K_COMMA); tx_q.push_back(D_I2);
            end else begin
                tx_q.push_back(K_COMMA); tx_q.push_back(D_I1);
            end
        end
    endtask

    task automatic add_run(input logic [8:0] tail, input int sets);
        repeat (sets) begin
            tx_q.push_back(K_COMMA); tx_q.push_back(tail);
        end
    endtask

    // Expected stream: everything but complete K28.5 + D16.2 sets
    task automatic log_input(input logic [8:0] s);
        if (in_pend) begin
            in_pend = 0;
            if (s == D_I2) return;
            exp_q.push_back(K_COMMA);
        end
        if (s == K_COMMA) in_pend = 1;
        else exp_q.push_back(s);
    endtask

    task automatic compare_one(input logic [8:0] s);
        logic [8:0] e;
        if (exp_q.size() == 0) begin
            check(0, "R1", "unexpected output symbol", int'(s), -1);
        end else begin
            e = exp_q.pop_front();
            check(s == e, "R1 R3", "stream symbol", int'(s), int'(e));
        end
    endtask

    task automatic log_output(input logic [8:0] s);
        if (out_pend) begin
            out_pend = 0;
            if (s == D_I2) return;
            compare_one(K_COMMA);
        end
        if (s == K_COMMA) out_pend = 1;
        else compare_one(s);
    endtask

    // Writer: one symbol per write clock, driven at the falling edge
    initial begin
        logic [8:0] cur;
        wait (wr_go);
        forever begin
            if (tx_q.size() == 0) add_chunk();
            cur     = tx_q.pop_front();
            in_k    = cur[8];
            in_data = cur[7:0];
            sync_ok = want_sync;
            log_input(cur);
            @(negedge wr_clk);
        end
    end

    // R6 monitor on the write side
    always @(negedge wr_clk) begin
        if (wr_mon) begin
            if (del_flag) begin
                del_run++;
            end else if (del_run != 0) begin
                check(del_run % 2 == 0, "R6", "del_flag run length even", del_run, del_run + del_run % 2);
                del_sets += del_run / 2;
                del_run = 0;
            end
        end
    end

    // Read side monitor: R5, R7 and stream comparison
    always @(negedge rd_clk) begin
        logic [8:0] s;
        if (rd_mon) begin
            s = {out_k, out_data};
            if (ins_flag) begin
                check(out_valid, "R7", "ins_flag without valid output", int'(out_valid), 1);
                if (!prev_ins) begin
                    check(last2 == K_COMMA && last1 == D_I2, "R5", "added set follows a complete set",
                          int'(last1), int'(D_I2));
                end
                check(s == (ins_pos == 0 ? K_COMMA : D_I2), "R7", "added symbol",
                      int'(s), int'(ins_pos == 0 ? K_COMMA : D_I2));
                if (ins_pos == 1) ins_sets++;
                ins_pos = 1 - ins_pos;
            end else if (prev_ins) begin
                check(ins_pos == 0, "R7", "ins_flag run ends on set boundary", ins_pos, 0);
                ins_pos = 0;
            end
            prev_ins = ins_flag;
            if (out_valid) begin
                log_output(s);
                last2 = last1;
                last1 = s;
            end
        end
    end

    initial begin
        int d0, i0;
        seed_val = $urandom(32'h1d1e5eed);
        repeat (5) @(negedge rd_clk);
        // R8 reset state
        check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
        check(out_k == 1'b0 && out_data == 8'h00, "R8", "output symbol in reset", int'({out_k, out_data}), 0);
        check(del_flag == 1'b0, "R8", "del_flag in reset", int'(del_flag), 0);
        check(ins_flag == 1'b0, "R8", "ins_flag in reset", int'(ins_flag), 0);

        wr_half = CLK_PERIOD * 0.502;
        @(negedge wr_clk);
        wr_rst = 1'b0; wr_go = 1; wr_mon = 1;
        @(negedge rd_clk);
        rd_rst = 1'b0; rd_mon = 1;

        // R2: no correction before lock
        repeat (300) @(negedge rd_clk);
        check(del_sets == 0 && del_run == 0, "R2", "removed sets before lock", del_sets, 0);
        check(ins_sets == 0 && !ins_flag, "R2", "added sets before lock", ins_sets, 0);

        // R5: lock with a nearly empty buffer primes it with added sets
        want_sync = 1;
        repeat (600) @(negedge rd_clk);
        check(ins_sets > 0, "R5", "priming sets added", ins_sets, 1);

        // Fast write clock: removals only (R4), with a long run of the other idle form (R3)
        wr_half = CLK_PERIOD * 0.46;
        repeat (300) @(negedge rd_clk);
        i0 = ins_sets; d0 = del_sets;
        add_run(D_I1, 40);
        repeat (2700) @(negedge rd_clk);
        check(del_sets > d0, "R4", "sets removed with fast writer", del_sets - d0, 1);
        check(ins_sets == i0, "R5", "no set added with fast writer", ins_sets - i0, 0);

        // Slow write clock: additions only, with a long run of removable sets
        wr_half = CLK_PERIOD * 0.54;
        repeat (300) @(negedge rd_clk);
        i0 = ins_sets; d0 = del_sets;
        add_run(D_I2, 20);
        repeat (2700) @(negedge rd_clk);
        check(ins_sets > i0, "R5", "sets added with slow writer", ins_sets - i0, 1);
        check(del_sets == d0, "R4", "no set removed with slow writer", del_sets - d0, 0);

        // Tail: near-equal clocks, then idles only so all data drains (R1)
        wr_half = CLK_PERIOD * 0.502;
        repeat (300) @(negedge rd_clk);
        idle_only = 1;
        repeat (400) @(negedge rd_clk);
        check(exp_q.size() == 0, "R1", "data symbols still missing", exp_q.size(), 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule